// File: doc/BRIEF.md
# Relocatable Host-Bridge Register Bank

This block is the 32-bit register file that a system-bus-to-PCI host bridge exposes to the processor. It answers inside a 4 KB window whose base address is not fixed: software moves the window at run time by writing a dedicated base register. The bank holds several groups of PCI address-decode registers, each with its own writable-bit mask, a configuration-address register, and two sync-barrier locations that always read back a fixed pattern.

Byte order is chosen at run time. A control bit in the bridge command register sets whether write data is byte-reversed before it is stored and whether read data is byte-reversed before it is returned. Every access takes one cycle. Read data comes from a register and is flagged by an acknowledge pulse one cycle after the request. The bank also reports whether the address currently on its bus falls inside its window.

Top module: `brg_regbank`

## Requirements
- R1: After reset the base register holds RST_SPACE (default 0x00DF, so the window starts at 0x1BE00000) and the command register holds 0, so byte reversal is active.
- R2: The register index is address bits [11:2]. `win_hit` is high exactly when address bits [31:12] equal bits [31:12] of (base register << 21). Base register values that place the window at or above 4 GB give no hit.
- R3: A write that hits the base register (index 0x001) moves the window at once. Accesses to the old window then produce no acknowledge and change no state.
- R4: Command register (index 0x000, bit 0 stored, mask 0x1). When bit 0 is 0, write data is byte-reversed before use and read data is byte-reversed before it is returned. When bit 0 is 1, data passes through unchanged. A write to the command register is itself decoded using the old value of bit 0.
- R5: Decode group k (k = 0..NUM_WIN-1) has a low register at index 0x010+4k, a high register at 0x011+4k and a remap register at 0x012+4k. A write to the low register stores the data masked with 0x7fff and also loads the remap register with the data masked with 0x7ff.
- R6: A high register keeps data masked with 0x7f. A direct write to a remap register keeps data masked with 0x7ff.
- R7: The configuration-address register (index 0x040) stores data masked with 0x80fffffc.
- R8: The sync-barrier locations (index 0x041 and 0x042) read 0xc000ffee before any byte reversal. Writes to them have no effect.
- R9: Unimplemented indexes read as 0, and writes to them have no effect.
- R10: A read that hits the window raises `rd_ack` in the next cycle, with the result on `rd_data`. `rd_data` changes only together with `rd_ack`.
- R11: The base register keeps only the low 15 bits of the data (mask 0x7fff).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_waddr | input | 30 | Word address, bits [31:2] of the byte address |
| acc_wdata | input | 32 | Write data as seen on the bus |
| win_hit | output | 1 | Address lies inside the current window |
| rd_ack | output | 1 | Read result valid on rd_data |
| rd_data | output | 32 | Registered read data, after optional byte reversal |

## Verification
The hardest case to reach is relocation combined with a byte-order change. The write that moves the window is decoded through the byte-reversal path, and after it the old address must stop responding. The stimulus reaches this state in three steps. It first reads the base register while byte reversal is still active, then switches the order through a write whose data is itself reversed. Finally it moves the window and checks that the old address gives no acknowledge, while the new address returns the stored value and the 15-bit mask.

// File: rtl/brg_pkg.sv
package brg_pkg;
   localparam int IDX_CMD   = 'h000;
   localparam int IDX_SPACE = 'h001;
   localparam int IDX_GRP0  = 'h010;
   localparam int GRP_STEP  = 4;
   localparam int IDX_CFGA  = 'h040;
   localparam int IDX_SYNCA = 'h041;
   localparam int IDX_SYNCB = 'h042;

   localparam logic [31:0] SYNC_PATTERN = 32'hc000ffee;
   localparam logic [31:0] CFGA_MASK    = 32'h80fffffc;

   function automatic logic [31:0] bswap32(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction
endpackage

// File: rtl/brg_win_match.sv
module brg_win_match #(
   parameter int ADDR_W     = 32,
   parameter int SPACE_W    = 15,
   parameter int BASE_SHIFT = 21,
   parameter int WIN_BITS   = 12
) (
   input  logic [SPACE_W-1:0]   space,
   input  logic [ADDR_W-1:2]    waddr,
   output logic                 hit
);
   localparam int CMP_W = SPACE_W + BASE_SHIFT - WIN_BITS;
   localparam int PAD_W = BASE_SHIFT - WIN_BITS;

   logic [CMP_W-1:0] base_page;
   logic [CMP_W-1:0] addr_page;

   generate
      if (PAD_W > 0) begin : g_pad
         assign base_page = {space, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign base_page = space;
      end
   endgenerate

   assign addr_page = CMP_W'(waddr[ADDR_W-1:WIN_BITS]);
   assign hit = (base_page == addr_page);
endmodule

// File: rtl/brg_pci_group.sv
module brg_pci_group #(
   parameter int IDX_W    = 10,
   parameter int BASE_IDX = 'h010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [14:0]      wd,
   output logic             rd_sel,
   output logic [31:0]      rd_val
);
   localparam logic [IDX_W-1:0] I_LO = IDX_W'(BASE_IDX);
   localparam logic [IDX_W-1:0] I_HI = IDX_W'(BASE_IDX + 1);
   localparam logic [IDX_W-1:0] I_RM = IDX_W'(BASE_IDX + 2);

   logic [14:0] lo_q;
   logic [6:0]  hi_q;
   logic [10:0] rm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
         rm_q <= '0;
      end else if (wr_en) begin
         if (idx == I_LO) begin
            lo_q <= wd;
            rm_q <= wd[10:0];
         end
         if (idx == I_HI) hi_q <= wd[6:0];
         if (idx == I_RM) rm_q <= wd[10:0];
      end
   end

   always_comb begin
      rd_sel = 1'b1;
      rd_val = '0;
      unique case (idx)
         I_LO:    rd_val = 32'(lo_q);
         I_HI:    rd_val = 32'(hi_q);
         I_RM:    rd_val = 32'(rm_q);
         default: rd_sel = 1'b0;
      endcase
   end
endmodule

// File: rtl/brg_regbank.sv
module brg_regbank #(
   parameter int              ADDR_W     = 32,
   parameter int              SPACE_W    = 15,
   parameter int              BASE_SHIFT = 21,
   parameter int              WIN_BITS   = 12,
   parameter int              NUM_WIN    = 4,
   parameter logic [14:0]     RST_SPACE  = 15'h00DF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:2] acc_waddr,
   input  logic [31:0]       acc_wdata,
   output logic              win_hit,
   output logic              rd_ack,
   output logic [31:0]       rd_data
);
   import brg_pkg::*;

   localparam int IDX_W = WIN_BITS - 2;

   generate
      if (SPACE_W != 15) begin : g_bad_space
         $error("SPACE_W must be 15");
      end
      if (ADDR_W > SPACE_W + BASE_SHIFT || BASE_SHIFT < WIN_BITS) begin : g_bad_geom
         $error("window geometry out of range");
      end
      if (IDX_GRP0 + GRP_STEP * NUM_WIN > IDX_CFGA || IDX_SYNCB >= (1 << IDX_W)) begin : g_bad_map
         $error("register map overlaps");
      end
   endgenerate

   logic [IDX_W-1:0]   idx;
   logic               noswap_q;
   logic [SPACE_W-1:0] space_q;
   logic [31:0]        cfga_q;
   logic [31:0]        wd;
   logic               wr_fire, rd_fire;
   logic [31:0]        rd_mux;
   logic [NUM_WIN-1:0] grp_sel;
   logic [31:0]        grp_val [NUM_WIN];

   assign idx = acc_waddr[WIN_BITS-1:2];

   brg_win_match #(
      .ADDR_W(ADDR_W), .SPACE_W(SPACE_W),
      .BASE_SHIFT(BASE_SHIFT), .WIN_BITS(WIN_BITS)
   ) u_match (
      .space(space_q), .waddr(acc_waddr), .hit(win_hit)
   );

   assign wr_fire = acc_valid &&  acc_write && win_hit;
   assign rd_fire = acc_valid && !acc_write && win_hit;
   assign wd      = noswap_q ? acc_wdata : bswap32(acc_wdata);

   genvar k;
   generate
      for (k = 0; k < NUM_WIN; k++) begin : g_grp
         brg_pci_group #(
            .IDX_W(IDX_W), .BASE_IDX(IDX_GRP0 + GRP_STEP * k)
         ) u_grp (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .idx(idx),
            .wd(wd[14:0]), .rd_sel(grp_sel[k]), .rd_val(grp_val[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         noswap_q <= 1'b0;
         space_q  <= RST_SPACE;
         cfga_q   <= '0;
      end else if (wr_fire) begin
         if (idx == IDX_W'(IDX_CMD))   noswap_q <= wd[0];
         if (idx == IDX_W'(IDX_SPACE)) space_q  <= wd[SPACE_W-1:0];
         if (idx == IDX_W'(IDX_CFGA))  cfga_q   <= wd & CFGA_MASK;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (grp_sel[i]) rd_mux = rd_mux | grp_val[i];
      end
      if (idx == IDX_W'(IDX_CMD))   rd_mux = 32'(noswap_q);
      if (idx == IDX_W'(IDX_SPACE)) rd_mux = 32'(space_q);
      if (idx == IDX_W'(IDX_CFGA))  rd_mux = cfga_q;
      if (idx == IDX_W'(IDX_SYNCA) || idx == IDX_W'(IDX_SYNCB)) rd_mux = SYNC_PATTERN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= rd_fire;
         if (rd_fire) rd_data <= noswap_q ? rd_mux : bswap32(rd_mux);
      end
   end
endmodule

// File: rtl/brg_regbank_chk.sv
module brg_regbank_chk #(
   parameter int IDX_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_write,
   input logic [IDX_W-1:0] idx,
   input logic [31:0]      acc_wdata,
   input logic             win_hit,
   input logic             rd_ack,
   input logic [31:0]      rd_data,
   input logic             noswap,
   input logic [14:0]      space
);
   import brg_pkg::*;

   logic [31:0] wd_rev;
   logic [14:0] exp_space;
   logic        rd_req, sync_req, space_wr;
   logic [31:0] sync_exp;

   assign wd_rev    = bswap32(acc_wdata);
   assign exp_space = noswap ? acc_wdata[14:0] : wd_rev[14:0];
   assign rd_req    = acc_valid && !acc_write && win_hit;
   assign sync_req  = rd_req && (idx == IDX_W'(IDX_SYNCA) || idx == IDX_W'(IDX_SYNCB));
   assign space_wr  = acc_valid && acc_write && win_hit && idx == IDX_W'(IDX_SPACE);
   assign sync_exp  = noswap ? SYNC_PATTERN : bswap32(SYNC_PATTERN);

   AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_ack); // R10
   AST_NO_ACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !win_hit) |=> !rd_ack); // R3
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ack |-> $stable(rd_data)); // R10
   AST_SYNC_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> rd_data == $past(sync_exp)); // R8
   AST_BASE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      space_wr |=> space == $past(exp_space)); // R11
endmodule

bind brg_regbank brg_regbank_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .idx(idx), .acc_wdata(acc_wdata), .win_hit(win_hit), .rd_ack(rd_ack),
   .rd_data(rd_data), .noswap(noswap_q), .space(space_q)
);

// File: tb/brg_regbank_bench.sv
module brg_regbank_bench;
   localparam int CLK_PER = 10;
   localparam logic [31:0] BASE0 = 32'h1BE00000;
   localparam logic [31:0] BASE1 = 32'h1C000000;
   localparam int NV = 15;
   // {write, index, data, expected read, requirement}
   localparam logic [78:0] TBL [NV] = '{
      {1'b1, 10'h010, 32'hFFFFFFFF, 32'h0,        4'd5},  // R5
      {1'b0, 10'h010, 32'h0,        32'h00007fff, 4'd5},  // R5
      {1'b0, 10'h012, 32'h0,        32'h000007ff, 4'd5},  // R5
      {1'b1, 10'h015, 32'h12345678, 32'h0,        4'd6},  // R6
      {1'b0, 10'h015, 32'h0,        32'h00000078, 4'd6},  // R6
      {1'b1, 10'h01A, 32'hABCDEF01, 32'h0,        4'd6},  // R6
      {1'b0, 10'h01A, 32'h0,        32'h00000701, 4'd6},  // R6
      {1'b1, 10'h01C, 32'h00001234, 32'h0,        4'd5},  // R5
      {1'b0, 10'h01E, 32'h0,        32'h00000234, 4'd5},  // R5
      {1'b1, 10'h040, 32'hFFFFFFFF, 32'h0,        4'd7},  // R7
      {1'b0, 10'h040, 32'h0,        32'h80fffffc, 4'd7},  // R7
      {1'b1, 10'h041, 32'h00000001, 32'h0,        4'd8},  // R8
      {1'b0, 10'h042, 32'h0,        32'hc000ffee, 4'd8},  // R8
      {1'b1, 10'h03F, 32'hFFFFFFFF, 32'h0,        4'd9},  // R9
      {1'b0, 10'h03F, 32'h0,        32'h00000000, 4'd9}   // R9
   };

   logic        clk = 0, rst_n = 0;
   logic        acc_valid = 0, acc_write = 0;
   logic [31:2] acc_waddr = '0;
   logic [31:0] acc_wdata = '0;
   logic        win_hit, rd_ack;
   logic [31:0] rd_data;
   int checks = 0, errors = 0;

   always #(CLK_PER/2) clk = ~clk;

   brg_regbank u_brg_regbank (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_waddr(acc_waddr), .acc_wdata(acc_wdata), .win_hit(win_hit),
      .rd_ack(rd_ack), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [31:0] base, input logic [9:0] idx, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_waddr = {base[31:12], idx}; acc_wdata = d;
      @(negedge clk);
      acc_valid = 0; acc_write = 0;
   endtask

   task automatic do_rd(input logic [31:0] base, input logic [9:0] idx,
                        output logic ack, output logic [31:0] d);
      @(negedge clk);
      acc_valid = 1; acc_write = 0; acc_waddr = {base[31:12], idx};
      @(negedge clk);
      acc_valid = 0;
      ack = rd_ack; d = rd_data;
   endtask

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      report();
   end

   initial begin
      logic ack;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state, reversal active
      chk("R1 rd_ack", 32'(rd_ack), 0);
      acc_waddr = {BASE0[31:12], 10'h000};
      #1 chk("R2 hit at reset base", 32'(win_hit), 1);
      acc_waddr = {BASE1[31:12], 10'h000};
      #1 chk("R2 no hit elsewhere", 32'(win_hit), 0);
      do_rd(BASE0, 10'h000, ack, d);
      chk("R1 cmd", d, 32'h0);
      chk("R10 ack", 32'(ack), 1);
      do_rd(BASE0, 10'h001, ack, d);
      chk("R4 space reversed", d, 32'hDF000000);
      chk("R10 held", rd_data, 32'hDF000000);
      // R4: set no-swap using reversed data
      do_wr(BASE0, 10'h000, 32'h01000000);
      do_rd(BASE0, 10'h000, ack, d);
      chk("R4 cmd set", d, 32'h00000001);
      for (int i = 0; i < NV; i++) begin
         if (TBL[i][78]) begin
            do_wr(BASE0, TBL[i][77:68], TBL[i][67:36]);
         end else begin
            do_rd(BASE0, TBL[i][77:68], ack, d);
            chk($sformatf("R%0d vector %0d", TBL[i][3:0], i), d, TBL[i][35:4]);
         end
      end
      // R3: relocate window
      do_wr(BASE0, 10'h001, 32'h000000E0);
      do_rd(BASE0, 10'h000, ack, d);
      chk("R3 old base silent", 32'(ack), 0);
      do_wr(BASE0, 10'h040, 32'h0);
      do_rd(BASE1, 10'h001, ack, d);
      chk("R3 new base", d, 32'h000000E0);
      do_rd(BASE1, 10'h040, ack, d);
      chk("R3 old-base write ignored", d, 32'h80fffffc);
      // R11: mask on base register
      do_wr(BASE1, 10'h001, 32'hFFFF80E0);
      do_rd(BASE1, 10'h001, ack, d);
      chk("R11 space mask", d, 32'h000000E0);
      // R2: out-of-range base gives no hit
      acc_waddr = {BASE1[31:12], 10'h000};
      #1 chk("R2 hit new base", 32'(win_hit), 1);
      // R4: back to reversal
      do_wr(BASE1, 10'h000, 32'h00000000);
      do_wr(BASE1, 10'h040, 32'h78563412);
      do_rd(BASE1, 10'h040, ack, d);
      chk("R4 reversed cfg", d, 32'h78563400);
      do_rd(BASE1, 10'h041, ack, d);
      chk("R8 reversed sync", d, 32'heeff00c0);
      do_wr(BASE1, 10'h001, 32'h00400000);
      acc_waddr = {BASE1[31:12], 10'h000};
      #1 chk("R2 base above 4GB no hit", 32'(win_hit), 0);
      report();
   end
endmodule